// File: doc/BRIEF.md
# General-purpose I/O controller with debounced interrupts

This block drives and senses up to 32 general-purpose lines from a small word-wide register bus. Software programs output levels and output enables, reads back the pins through a two-flop synchronizer, and sets pull configuration bits that the block only exports to the pad ring. Output bits can also be changed without read-modify-write, using separate write-one set and write-one clear offsets.

Every line feeds an interrupt unit. The unit has a per-line enable, edge or level detection, a polarity bit and an either-edge option. Raw status bits stay set until software clears them by writing ones. A mask register leaves the raw view unchanged but gates a masked view. The single interrupt output is the OR of the masked bits. Lines that have both debounce and interrupt enabled first pass through a glitch filter. All filters take their sample tick from one shared 24-bit divider of the bus clock.

The bus performs one access in each cycle where `bus_sel` is high. A write lands on the next rising edge. Read data is combinational in the same cycle.

Top module: `gpio_dbc_top`

## Requirements
- R1: After reset every register reads zero, `gpio_out`, `gpio_oe`, `pull_en`, `pull_sel` are zero and `irq` is low.
- R2: Offsets 0x00 (output level), 0x08 (output enable, 1 = drive), 0x18 (pull enable) and 0x1C (pull select) are read/write, and their values appear on `gpio_out`, `gpio_oe`, `pull_en` and `pull_sel` from the edge that writes them.
- R3: Writing offset 0x10 sets the output bits where the word has ones, and writing 0x14 clears them. Other bits are unchanged, and both offsets read as zero.
- R4: Offset 0x0C returns the synchronized pins, which change two rising edges after a pin changes. Offset 0x04 returns the filtered input view.
- R5: With offset 0x34 bit = 0 (edge), an enabled line (0x20 bit = 1) sets its raw bit on the third rising edge after the pin change. Offset 0x3C bit 0 selects rising and 1 selects falling. Offset 0x38 bit 1 selects either edge.
- R6: With offset 0x34 bit = 1 (level), the raw bit is set whenever the input is high (0x3C bit 0) or low (0x3C bit 1). A clear issued while the level persists leaves the bit set.
- R7: Offset 0x24 reads raw status whatever the mask. Offset 0x28 reads raw AND NOT mask, where a mask bit (0x2C) of 1 hides the line. `irq` is high exactly when 0x28 is non-zero.
- R8: Writing offset 0x30 clears only the raw bits where the word has ones. Raw bits fall only through such a write.
- R9: Debounce enable is at 0x40 and the 24-bit prescale is at 0x44, whose upper byte reads zero. A tick occurs every max(P,1) cycles. A filtered line changes only when two consecutive ticks sample the same new value, so a one-cycle pin pulse never passes while P is at least 2.
- R10: Debounce has no effect on a line whose interrupt enable is 0: offset 0x04 then follows 0x0C.
- R11: Reads of unmapped offsets return zero, and writes to them change no register.
- R12: A line whose interrupt enable is 0 never sets its raw bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle, zero when idle |
| gpio_in | input | N | Asynchronous pin inputs |
| gpio_out | output | N | Output levels |
| gpio_oe | output | N | Output enables |
| pull_en | output | N | Pull enable per line |
| pull_sel | output | N | Pull select per line |
| irq | output | 1 | Combined interrupt |

## Verification
The due times are fixed:
- A register write is visible from the first rising edge after the write cycle.
- The synchronized pin view is visible two edges after a pin change.
- A raw interrupt bit is visible three edges after a pin change, with `irq` following in the same cycle.

The bench changes pins and bus signals only just after a falling edge, counts the falling edges up to the due one, and samples there. For the edge detector it also confirms that the status is still clear one cycle before the due edge. Debounced results have no fixed phase. The bench therefore checks them at points outside the uncertainty: three edges after the change, when no filtered value can have moved, and twenty edges after, well past two ticks of a prescale of four.

// File: rtl/gpio_dbc_pkg.sv
package gpio_dbc_pkg;
   localparam int ADDR_W = 8;
   localparam int BUS_W  = 32;
   typedef logic [ADDR_W-1:0] addr_t;
   localparam addr_t OFS_DOUT  = 8'h00;
   localparam addr_t OFS_DIN   = 8'h04;
   localparam addr_t OFS_DIR   = 8'h08;
   localparam addr_t OFS_RAWIN = 8'h0C;
   localparam addr_t OFS_SET   = 8'h10;
   localparam addr_t OFS_CLR   = 8'h14;
   localparam addr_t OFS_PEN   = 8'h18;
   localparam addr_t OFS_PSEL  = 8'h1C;
   localparam addr_t OFS_IEN   = 8'h20;
   localparam addr_t OFS_RAW   = 8'h24;
   localparam addr_t OFS_MSKD  = 8'h28;
   localparam addr_t OFS_MASK  = 8'h2C;
   localparam addr_t OFS_ACK   = 8'h30;
   localparam addr_t OFS_TYPE  = 8'h34;
   localparam addr_t OFS_BOTH  = 8'h38;
   localparam addr_t OFS_POL   = 8'h3C;
   localparam addr_t OFS_DBEN  = 8'h40;
   localparam addr_t OFS_PRE   = 8'h44;
endpackage

// File: rtl/gpio_dbc_sync.sv
module gpio_dbc_sync #(
   parameter int N      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   if (STAGES < 2) begin : g_bad
      $error("gpio_dbc_sync: STAGES must be at least 2");
   end

   logic [N-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '0;
         else if (s == 0) stg[s] <= d;
         else stg[s] <= stg[(s > 0) ? s-1 : 0];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_dbc_filter.sv
module gpio_dbc_filter #(
   parameter int N     = 32,
   parameter int PRE_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRE_W-1:0] presc,
   input  logic [N-1:0]     active,
   input  logic [N-1:0]     d,
   output logic [N-1:0]     q,
   output logic [N-1:0]     filt,
   output logic             tick
);
   logic [PRE_W-1:0] cnt_q;
   logic [PRE_W-1:0] lim;
   logic [N-1:0]     samp_q, filt_q;

   assign lim  = (presc == '0) ? '0 : presc - 1'b1;
   assign tick = (cnt_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samp_q <= '0;
         filt_q <= '0;
      end else begin
         for (int i = 0; i < N; i++) begin
            if (!active[i]) begin
               samp_q[i] <= d[i];
               filt_q[i] <= d[i];
            end else if (tick) begin
               samp_q[i] <= d[i];
               if (d[i] == samp_q[i]) filt_q[i] <= d[i];
            end
         end
      end
   end

   assign q    = (filt_q & active) | (d & ~active);
   assign filt = filt_q;
endmodule

// File: rtl/gpio_dbc_irq.sv
module gpio_dbc_irq #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   input  logic [N-1:0] en,
   input  logic [N-1:0] is_level,
   input  logic [N-1:0] both,
   input  logic [N-1:0] pol,
   input  logic         ack_we,
   input  logic [N-1:0] ack,
   output logic [N-1:0] raw
);
   logic [N-1:0] prev_q, ev, edge_ev, lvl_ev;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         if (both[i]) edge_ev[i] = lvl[i] ^ prev_q[i];
         else if (pol[i]) edge_ev[i] = prev_q[i] & ~lvl[i];
         else edge_ev[i] = lvl[i] & ~prev_q[i];
         lvl_ev[i] = pol[i] ? ~lvl[i] : lvl[i];
      end
   end

   assign ev = en & ((is_level & lvl_ev) | (~is_level & edge_ev));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         raw    <= '0;
      end else begin
         prev_q <= lvl;
         raw    <= (raw & ~(ack_we ? ack : '0)) | ev;
      end
   end
endmodule

// File: rtl/gpio_dbc_top.sv
module gpio_dbc_top
   import gpio_dbc_pkg::*;
#(
   parameter int N           = 32,
   parameter int PRE_W       = 24,
   parameter int SYNC_STAGES = 2,
   parameter bit DBC_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [N-1:0]      gpio_in,
   output logic [N-1:0]      gpio_out,
   output logic [N-1:0]      gpio_oe,
   output logic [N-1:0]      pull_en,
   output logic [N-1:0]      pull_sel,
   output logic              irq
);
   if (N < 1 || N > BUS_W) begin : g_bad_n
      $error("gpio_dbc_top: N must be 1..32");
   end
   if (PRE_W < 1 || PRE_W > BUS_W) begin : g_bad_pre
      $error("gpio_dbc_top: PRE_W must be 1..32");
   end

   logic [N-1:0]     dout_q, dir_q, pen_q, psel_q, ien_q, mask_q;
   logic [N-1:0]     type_q, both_q, pol_q, dben_q;
   logic [PRE_W-1:0] pre_q;
   logic [N-1:0]     sync_in, filt_in, raw, masked, dbc_active, dbc_filt;
   logic             dbc_tick;
   logic             we;
   logic [N-1:0]     wd;

   assign we = bus_sel & bus_wr;
   assign wd = bus_wdata[N-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0; dir_q <= '0; pen_q <= '0; psel_q <= '0;
         ien_q  <= '0; mask_q <= '0; type_q <= '0; both_q <= '0;
         pol_q  <= '0; dben_q <= '0; pre_q <= '0;
      end else if (we) begin
         case (bus_addr)
            OFS_DOUT: dout_q <= wd;
            OFS_SET:  dout_q <= dout_q | wd;
            OFS_CLR:  dout_q <= dout_q & ~wd;
            OFS_DIR:  dir_q  <= wd;
            OFS_PEN:  pen_q  <= wd;
            OFS_PSEL: psel_q <= wd;
            OFS_IEN:  ien_q  <= wd;
            OFS_MASK: mask_q <= wd;
            OFS_TYPE: type_q <= wd;
            OFS_BOTH: both_q <= wd;
            OFS_POL:  pol_q  <= wd;
            OFS_DBEN: dben_q <= wd;
            OFS_PRE:  pre_q  <= bus_wdata[PRE_W-1:0];
            default: ;
         endcase
      end
   end

   gpio_dbc_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(gpio_in), .q(sync_in)
   );

   if (DBC_EN) begin : g_dbc
      assign dbc_active = dben_q & ien_q;
      gpio_dbc_filter #(.N(N), .PRE_W(PRE_W)) u_filt (
         .clk(clk), .rst_n(rst_n), .presc(pre_q), .active(dbc_active),
         .d(sync_in), .q(filt_in), .filt(dbc_filt), .tick(dbc_tick)
      );
   end else begin : g_nodbc
      assign dbc_active = '0;
      assign filt_in    = sync_in;
      assign dbc_filt   = sync_in;
      assign dbc_tick   = 1'b0;
   end

   gpio_dbc_irq #(.N(N)) u_irq (
      .clk(clk), .rst_n(rst_n), .lvl(filt_in), .en(ien_q),
      .is_level(type_q), .both(both_q), .pol(pol_q),
      .ack_we(we && bus_addr == OFS_ACK), .ack(wd), .raw(raw)
   );

   assign masked = raw & ~mask_q;
   assign irq    = |masked;

   function automatic logic [BUS_W-1:0] ext(input logic [N-1:0] v);
      logic [BUS_W-1:0] r;
      r = '0;
      r[N-1:0] = v;
      return r;
   endfunction

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         case (bus_addr)
            OFS_DOUT:  bus_rdata = ext(dout_q);
            OFS_DIN:   bus_rdata = ext(filt_in);
            OFS_DIR:   bus_rdata = ext(dir_q);
            OFS_RAWIN: bus_rdata = ext(sync_in);
            OFS_PEN:   bus_rdata = ext(pen_q);
            OFS_PSEL:  bus_rdata = ext(psel_q);
            OFS_IEN:   bus_rdata = ext(ien_q);
            OFS_RAW:   bus_rdata = ext(raw);
            OFS_MSKD:  bus_rdata = ext(masked);
            OFS_MASK:  bus_rdata = ext(mask_q);
            OFS_TYPE:  bus_rdata = ext(type_q);
            OFS_BOTH:  bus_rdata = ext(both_q);
            OFS_POL:   bus_rdata = ext(pol_q);
            OFS_DBEN:  bus_rdata = ext(dben_q);
            OFS_PRE:   bus_rdata[PRE_W-1:0] = pre_q;
            default:   bus_rdata = '0;
         endcase
      end
   end

   assign gpio_out = dout_q;
   assign gpio_oe  = dir_q;
   assign pull_en  = pen_q;
   assign pull_sel = psel_q;
endmodule

// File: rtl/gpio_dbc_chk.sv
module gpio_dbc_chk
   import gpio_dbc_pkg::*;
#(
   parameter int N = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic [BUS_W-1:0]  bus_rdata,
   input logic [N-1:0]      raw,
   input logic [N-1:0]      ien,
   input logic [N-1:0]      dout,
   input logic [N-1:0]      dbc_filt,
   input logic [N-1:0]      dbc_active,
   input logic              dbc_tick
);
   logic mapped;
   assign mapped = (bus_addr[1:0] == 2'b00) && (bus_addr <= OFS_DBEN || bus_addr == OFS_PRE);

   // R3: a set write ORs the word into the output level
   p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == OFS_SET) |=> dout == ($past(dout) | $past(bus_wdata[N-1:0])));

   // R8: raw bits fall only through a clear write
   p_fall_by_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((~raw & $past(raw)) != '0) |-> ($past(bus_sel) && $past(bus_wr) && $past(bus_addr) == OFS_ACK));

   // R12: a disabled line never raises its raw bit
   p_disabled_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (raw & ~$past(raw) & ~$past(ien)) == '0);

   // R9: a filtered active line moves only on a tick
   p_filt_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (((dbc_filt ^ $past(dbc_filt)) & $past(dbc_active)) != '0) |-> $past(dbc_tick));

   // R11: unmapped reads return zero
   p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && !mapped) |-> bus_rdata == '0);
endmodule

bind gpio_dbc_top gpio_dbc_chk #(.N(N)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .raw(raw), .ien(ien_q), .dout(dout_q), .dbc_filt(dbc_filt),
   .dbc_active(dbc_active), .dbc_tick(dbc_tick)
);

// File: tb/gpio_dbc_top_tb_top.sv
module gpio_dbc_top_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [N-1:0] gpio_in = '0;
   logic [N-1:0] gpio_out, gpio_oe, pull_en, pull_sel;
   logic        irq;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_dbc_top dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
      .pull_en(pull_en), .pull_sel(pull_sel), .irq(irq)
   );

   // {write offset, write data, read offset, expected, requirement}
   typedef logic [8+32+8+32+8-1:0] vec_t;
   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      {8'h00, 32'hA5A5_5A5A, 8'h00, 32'hA5A5_5A5A, 8'd2},  // R2
      {8'h10, 32'h0000_00FF, 8'h00, 32'hA5A5_5AFF, 8'd3},  // R3
      {8'h14, 32'hA000_000F, 8'h00, 32'h05A5_5AF0, 8'd3},  // R3
      {8'h10, 32'h0000_0000, 8'h10, 32'h0000_0000, 8'd3},  // R3
      {8'h08, 32'h1234_5678, 8'h08, 32'h1234_5678, 8'd2},  // R2
      {8'h18, 32'hF0F0_0000, 8'h18, 32'hF0F0_0000, 8'd2},  // R2
      {8'h1C, 32'h0F0F_0000, 8'h1C, 32'h0F0F_0000, 8'd2},  // R2
      {8'h2C, 32'hFFFF_0000, 8'h2C, 32'hFFFF_0000, 8'd7},  // R7
      {8'h2C, 32'h0000_0000, 8'h2C, 32'h0000_0000, 8'd7},  // R7
      {8'h44, 32'hFFFF_FFFF, 8'h44, 32'h00FF_FFFF, 8'd9},  // R9
      {8'h48, 32'hFFFF_FFFF, 8'h48, 32'h0000_0000, 8'd11}, // R11
      {8'h7C, 32'hDEAD_BEEF, 8'h00, 32'h05A5_5AF0, 8'd11}  // R11
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      cyc(2);
      rst_n = 1'b1;
      cyc(1);

      // R1 reset state
      rd(8'h00, v); chk("R1 dout", v, 0);
      rd(8'h08, v); chk("R1 dir", v, 0);
      rd(8'h24, v); chk("R1 raw", v, 0);
      rd(8'h44, v); chk("R1 presc", v, 0);
      chk("R1 pins", {gpio_out | gpio_oe | pull_en | pull_sel}, 0);
      chk("R1 irq", {31'b0, irq}, 0);

      for (int i = 0; i < NV; i++) begin
         logic [7:0] wa, ra, rq;
         logic [31:0] wv, ev;
         {wa, wv, ra, ev, rq} = VECS[i];
         wr(wa, wv);
         rd(ra, v);
         chk($sformatf("R%0d vector %0d", rq, i), v, ev);
      end
      wr(8'h00, 0); wr(8'h08, 0); wr(8'h18, 0); wr(8'h1C, 0); wr(8'h44, 0);

      // R2 pins
      wr(8'h00, 32'h0000_00F0); chk("R2 gpio_out", gpio_out, 32'hF0);
      wr(8'h08, 32'h3);         chk("R2 gpio_oe", gpio_oe, 32'h3);
      wr(8'h18, 32'h5);         chk("R2 pull_en", pull_en, 32'h5);
      wr(8'h1C, 32'h6);         chk("R2 pull_sel", pull_sel, 32'h6);

      // R4 synchronizer latency, R12 disabled line
      gpio_in = 32'h100;
      cyc(1); rd(8'h0C, v); chk("R4 sync one edge", v, 0);
      cyc(1); rd(8'h0C, v); chk("R4 sync two edges", v, 32'h100);
      rd(8'h04, v); chk("R4 filtered view", v, 32'h100);
      cyc(2); rd(8'h24, v); chk("R12 disabled raw", v, 0);
      gpio_in = 0; cyc(4);

      // R5 edge detection setup
      wr(8'h20, 32'hF); wr(8'h34, 32'h4); wr(8'h3C, 32'h8); wr(8'h38, 32'h2);
      wr(8'h30, 32'hFFFF_FFFF);
      rd(8'h24, v); chk("R5 idle raw", v, 0);
      gpio_in = 32'h1;
      cyc(2); rd(8'h24, v); chk("R5 rising not yet", v, 0);
      cyc(1); rd(8'h24, v); chk("R5 rising third edge", v, 32'h1);
      chk("R7 irq on", {31'b0, irq}, 1);
      gpio_in = 32'h9; cyc(3); rd(8'h24, v); chk("R5 falling ignores rise", v, 32'h1);
      gpio_in = 32'h1; cyc(3); rd(8'h24, v); chk("R5 falling edge", v, 32'h9);
      gpio_in = 32'h3; cyc(3); rd(8'h24, v); chk("R5 both rise", v, 32'hB);
      wr(8'h30, 32'h2); rd(8'h24, v); chk("R8 per-line clear", v, 32'h9);
      gpio_in = 32'h1; cyc(3); rd(8'h24, v); chk("R5 both fall", v, 32'hB);

      // R7 mask
      wr(8'h2C, 32'hFFFF_FFFF);
      rd(8'h28, v); chk("R7 masked all", v, 0);
      chk("R7 irq masked", {31'b0, irq}, 0);
      rd(8'h24, v); chk("R7 raw under mask", v, 32'hB);
      wr(8'h2C, 32'h1); rd(8'h28, v); chk("R7 partial mask", v, 32'hA);
      wr(8'h2C, 0);
      wr(8'h30, 32'hFFFF_FFFF); rd(8'h24, v); chk("R8 clear all", v, 0);
      chk("R8 irq low", {31'b0, irq}, 0);

      // R6 level
      gpio_in = 32'h5; cyc(3); rd(8'h24, v); chk("R6 level high", v, 32'h4);
      wr(8'h30, 32'h4); rd(8'h24, v); chk("R6 level persists", v, 32'h4);
      gpio_in = 32'h1; cyc(3); wr(8'h30, 32'h4); rd(8'h24, v); chk("R6 level gone", v, 0);

      // R9 debounce on line 4
      wr(8'h20, 32'h1F); wr(8'h44, 32'd4); wr(8'h40, 32'h10); cyc(4);
      wr(8'h30, 32'hFFFF_FFFF);
      gpio_in = 32'h11; cyc(1); gpio_in = 32'h1; cyc(30);
      rd(8'h04, v); chk("R9 glitch blocked", v & 32'h10, 0);
      rd(8'h24, v); chk("R9 glitch no irq", v, 0);
      gpio_in = 32'h11; cyc(3);
      rd(8'h04, v); chk("R9 not yet filtered", v & 32'h10, 0);
      rd(8'h0C, v); chk("R4 bypass view", v & 32'h10, 32'h10);
      cyc(20);
      rd(8'h04, v); chk("R9 filtered passes", v & 32'h10, 32'h10);
      rd(8'h24, v); chk("R9 debounced edge", v, 32'h10);

      // R10 debounce ignored without interrupt enable
      wr(8'h20, 32'hF);
      gpio_in = 32'h1; cyc(2);
      rd(8'h04, v); chk("R10 follows sync", v & 32'h10, 0);

      finish_run();
   end
endmodule